// File: doc/BRIEF.md
# Keyboard controller host interface

This block is the host-facing side of a keyboard controller in the AT/PS2 tradition. It decodes two byte-wide ports. The data port sits at a base address that can be changed at run time, and the command/status port sits four bytes above it. The block holds the input buffer, the output buffer and the status flags. It drives two interrupt requests onto a bank of interrupt lines, and software chooses which line each request uses.

Most writes are passed to an external command processor through a valid/ready handoff. Four kinds of command complete entirely inside the block and never reach the processor:
- the gate-A20 update (a command byte, then one data byte),
- the output pulse commands,
- keyboard enable,
- keyboard disable.

The processor returns bytes to the host by loading the output buffer. It tags each byte as coming from the keyboard or from the auxiliary device.

Top module: `kbc_host_if`

## Requirements
- R1: The data port answers at the configured base and the command port at base + 4. The base resets to 0x0060 and is set by `cfg_sel`=0. A base of zero disables both ports. A port that is not decoded ignores writes and reads as 0xFF.
- R2: A data-port write clears status bit 3 (command/data flag). A command-port write sets it.
- R3: A write that is not fast-pathed stores its byte and sets status bit 1 (input full). The byte is then offered on `cp_data` with `cp_valid`, and `cp_is_cmd` is high when the write went to the command port. Input full clears on the cycle after `cp_valid` and `cp_ready` are both high.
- R4: Command 0xD1 arms a one-shot wait. The next data write replaces only bit 1 of `p2_out` with data bit 1. Neither byte is forwarded. Any other port write cancels the wait.
- R5: A command in 0xF0..0xFF is not forwarded. It raises `pulse_out[i]` for every i where bit i of its low nibble is 0. The pulse lasts exactly PULSE_LEN cycles and starts the cycle after the write.
- R6: Command 0xAD clears `kbd_en` and command 0xAE sets it. Neither is forwarded.
- R7: Every fast-pathed write forces input full low. Any byte still waiting for the processor is dropped, so `cp_valid` falls.
- R8: A data-port read returns the output buffer and clears status bit 0 (output full) on the next cycle. If `ob_load` arrives in the same cycle, the new byte wins and output full stays set.
- R9: A command-port read returns the status byte and changes no state.
- R10: The primary request is high while output full is set, the byte is tagged keyboard, and `ccb_int_en[0]` is set. The auxiliary request is high while output full is set, the byte is tagged auxiliary, and `ccb_int_en[1]` is set. Status bit 5 shows the auxiliary tag.
- R11: The primary selector (`cfg_sel`=1) resets to line 1 and the auxiliary selector (`cfg_sel`=2) resets to line 12. A selector of 0xFFFF, or any value of NUM_IRQ or more, connects that request to no line.
- R12: Synchronous active-low reset leaves the status byte at 0x00, `p2_out` at 0xFF, `kbd_en` at 1, no pulse, and `cp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 base, 1 primary line, 2 auxiliary line |
| cfg_wdata | input | 16 | Configuration value |
| bus_addr | input | 16 | Host I/O address |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte (combinational) |
| cp_valid | output | 1 | Byte waiting for the command processor |
| cp_ready | input | 1 | Command processor takes the byte |
| cp_data | output | 8 | Forwarded byte |
| cp_is_cmd | output | 1 | Forwarded byte came from the command port |
| ob_load | input | 1 | Processor loads the output buffer |
| ob_byte | input | 8 | Byte to load |
| ob_aux | input | 1 | Loaded byte belongs to the auxiliary device |
| ccb_int_en | input | 2 | Interrupt enables from the configuration byte: bit 0 primary, bit 1 auxiliary |
| irq_lines | output | NUM_IRQ | Interrupt line bank |
| p2_out | output | 8 | Output port; bit 1 is gate A20 |
| kbd_en | output | 1 | Keyboard interface enabled |
| pulse_out | output | PULSE_LINES | Pulse outputs |

## Verification
The bench targets five corner cases, each of which a faulty design would get wrong in a visible way:
- **One-shot A20 wait.** The bench sends a second data byte after the A20 update. A design that keeps the wait armed would swallow that byte instead of forwarding it.
- **Fast path while a byte is pending.** The bench sends a fast-path command while a byte is still queued. A design that forgets to drop input full would let the stale byte run.
- **Pulse length and inverted mask.** The bench counts the pulse cycles exactly. An inverted mask or an off-by-one counter shows up in that count.
- **Simultaneous load and read.** The bench loads and reads the output buffer in the same cycle. A design where the read wins loses the new byte.
- **Disconnected and relocated lines.** The bench moves the base and both interrupt selectors, including to the disconnected encoding. A design that still answers at the old address, or still drives a line after disconnection, is caught.

// File: rtl/kbc_pkg.sv
// Package: shared constants for the keyboard controller host interface.
// Assumes the status bit positions are fixed, because host software decodes them.
package kbc_pkg;
    localparam int STAT_OBF = 0;
    localparam int STAT_IBF = 1;
    localparam int STAT_CD  = 3;
    localparam int STAT_AUX = 5;

    localparam logic [7:0] CMD_GATE_A20 = 8'hD1;
    localparam logic [7:0] CMD_KBD_OFF  = 8'hAD;
    localparam logic [7:0] CMD_KBD_ON   = 8'hAE;
    localparam logic [3:0] CMD_PULSE_HI = 4'hF;

    localparam logic [15:0] IRQ_UNCONNECTED = 16'hFFFF;

    typedef enum logic [1:0] {
        CFG_BASE = 2'd0,
        CFG_PRI  = 2'd1,
        CFG_AUX  = 2'd2
    } cfg_sel_e;
endpackage

// File: rtl/kbc_port_decode.sv
// Module: decodes the data port at base and the command port at base + CMD_OFFSET.
// Assumes single-address ports; a base of zero turns decoding off.
module kbc_port_decode #(
    parameter int ADDR_W     = 16,
    parameter int CMD_OFFSET = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_data,
    output logic              hit_cmd
);
    localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(CMD_OFFSET);

    logic enabled;

    // Compare the address against both port locations.
    always_comb begin
        enabled  = (base != '0);
        hit_data = enabled && (addr == base);
        hit_cmd  = enabled && (addr == base + OFFS);
    end
endmodule

// File: rtl/kbc_irq_steer.sv
// Module: routes the primary and auxiliary requests onto a bank of lines.
// Assumes a selector that matches no line index leaves its request unconnected.
module kbc_irq_steer #(
    parameter int NUM_IRQ = 16,
    parameter int SEL_W   = 16
) (
    input  logic [SEL_W-1:0]   pri_sel,
    input  logic [SEL_W-1:0]   aux_sel,
    input  logic               pri_req,
    input  logic               aux_req,
    output logic [NUM_IRQ-1:0] irq_lines
);
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
        // Each line ORs in whichever request targets it.
        always_comb begin
            irq_lines[i] = ((pri_sel == IDX) && pri_req) || ((aux_sel == IDX) && aux_req);
        end
    end
endmodule

// File: rtl/kbc_pulse_gen.sv
// Module: drives selected pulse lines high for LEN cycles after a fire strobe.
// Assumes a zero bit in sel_n selects a line; a new fire restarts the pulse.
module kbc_pulse_gen #(
    parameter int LINES = 4,
    parameter int LEN   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [LINES-1:0] sel_n,
    output logic [LINES-1:0] pulse_out
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LEN_C = CW'(LEN);

    logic [CW-1:0]    cnt_q;
    logic [LINES-1:0] mask_q;

    // Load the mask and count on fire, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mask_q <= '0;
        end else if (fire) begin
            cnt_q  <= LEN_C;
            mask_q <= ~sel_n;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Drive the mask only while the count is running.
    always_comb begin
        pulse_out = (cnt_q != '0) ? mask_q : '0;
    end

    p_pulse_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (pulse_out == ~$past(sel_n)));
endmodule

// File: rtl/kbc_host_if.sv
// Module: host register interface of the keyboard controller.
// Holds the status, input and output buffers; fast-paths A20, pulse and keyboard
// enable commands; forwards everything else to a command processor by valid/ready.
// Assumes one host access per cycle and reads that sample bus_rdata combinationally.
module kbc_host_if
    import kbc_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int NUM_IRQ     = 16,
    parameter int PULSE_LINES = 4,
    parameter int PULSE_LEN   = 4,
    parameter int BASE_RESET  = 16'h0060,
    parameter int PRI_RESET   = 1,
    parameter int AUX_RESET   = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_sel,
    input  logic [15:0]            cfg_wdata,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [7:0]             bus_wdata,
    output logic [7:0]             bus_rdata,
    output logic                   cp_valid,
    input  logic                   cp_ready,
    output logic [7:0]             cp_data,
    output logic                   cp_is_cmd,
    input  logic                   ob_load,
    input  logic [7:0]             ob_byte,
    input  logic                   ob_aux,
    input  logic [1:0]             ccb_int_en,
    output logic [NUM_IRQ-1:0]     irq_lines,
    output logic [7:0]             p2_out,
    output logic                   kbd_en,
    output logic [PULSE_LINES-1:0] pulse_out
);
    localparam int SEL_W = 16;

    logic [ADDR_W-1:0] base_q;
    logic [SEL_W-1:0]  pri_sel_q, aux_sel_q;
    logic              obf_q, ibf_q, cd_q, aux_q, a20_wait_q, kbd_en_q;
    logic [7:0]        ib_q, ob_q, p2_q;
    logic              ib_cmd_q;

    logic hit_data, hit_cmd;
    logic wr_data, wr_cmd, rd_data;
    logic a20_fill, cmd_a20, cmd_pulse, cmd_off, cmd_on, fast, fwd, accept;
    logic pri_req, aux_req;
    logic [7:0] status;

    kbc_port_decode #(.ADDR_W(ADDR_W), .CMD_OFFSET(4)) u_dec (
        .base     (base_q),
        .addr     (bus_addr),
        .hit_data (hit_data),
        .hit_cmd  (hit_cmd)
    );

    // Classify this cycle's host access and the fast-path commands.
    always_comb begin
        wr_data   = bus_wr && hit_data;
        wr_cmd    = bus_wr && hit_cmd;
        rd_data   = bus_rd && hit_data;
        a20_fill  = wr_data && a20_wait_q;
        cmd_a20   = wr_cmd && (bus_wdata == CMD_GATE_A20);
        cmd_pulse = wr_cmd && (bus_wdata[7:4] == CMD_PULSE_HI);
        cmd_off   = wr_cmd && (bus_wdata == CMD_KBD_OFF);
        cmd_on    = wr_cmd && (bus_wdata == CMD_KBD_ON);
        fast      = a20_fill || cmd_a20 || cmd_pulse || cmd_off || cmd_on;
        fwd       = (wr_data || wr_cmd) && !fast;
        accept    = ibf_q && cp_ready;
    end

    // Run-time configuration of the port base and both line selectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= ADDR_W'(BASE_RESET);
            pri_sel_q <= SEL_W'(PRI_RESET);
            aux_sel_q <= SEL_W'(AUX_RESET);
        end else if (cfg_we) begin
            case (cfg_sel)
                CFG_BASE: base_q    <= cfg_wdata[ADDR_W-1:0];
                CFG_PRI:  pri_sel_q <= cfg_wdata;
                CFG_AUX:  aux_sel_q <= cfg_wdata;
                default:  ;
            endcase
        end
    end

    // Input side: command/data flag, input buffer, A20 wait, P2, keyboard enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cd_q       <= 1'b0;
            ibf_q      <= 1'b0;
            ib_q       <= 8'h00;
            ib_cmd_q   <= 1'b0;
            a20_wait_q <= 1'b0;
            p2_q       <= 8'hFF;
            kbd_en_q   <= 1'b1;
        end else begin
            if (wr_data) cd_q <= 1'b0;
            if (wr_cmd)  cd_q <= 1'b1;
            if (fast) begin
                ibf_q <= 1'b0;
            end else if (fwd) begin
                ibf_q    <= 1'b1;
                ib_q     <= bus_wdata;
                ib_cmd_q <= wr_cmd;
            end else if (accept) begin
                ibf_q <= 1'b0;
            end
            if (cmd_a20)                  a20_wait_q <= 1'b1;
            else if (wr_data || wr_cmd)   a20_wait_q <= 1'b0;
            if (a20_fill) p2_q[1] <= bus_wdata[1];
            if (cmd_off)  kbd_en_q <= 1'b0;
            if (cmd_on)   kbd_en_q <= 1'b1;
        end
    end

    // Output side: a processor load wins over a host read in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ob_q  <= 8'h00;
            obf_q <= 1'b0;
            aux_q <= 1'b0;
        end else if (ob_load) begin
            ob_q  <= ob_byte;
            obf_q <= 1'b1;
            aux_q <= ob_aux;
        end else if (rd_data) begin
            obf_q <= 1'b0;
        end
    end

    // Assemble status and the host read mux.
    always_comb begin
        status           = 8'h00;
        status[STAT_OBF] = obf_q;
        status[STAT_IBF] = ibf_q;
        status[STAT_CD]  = cd_q;
        status[STAT_AUX] = aux_q;
        if (bus_rd && hit_data)     bus_rdata = ob_q;
        else if (bus_rd && hit_cmd) bus_rdata = status;
        else                        bus_rdata = 8'hFF;
    end

    // Interrupt requests follow output-full, the tag and the configuration enables.
    always_comb begin
        pri_req = obf_q && !aux_q && ccb_int_en[0];
        aux_req = obf_q && aux_q && ccb_int_en[1];
    end

    kbc_irq_steer #(.NUM_IRQ(NUM_IRQ), .SEL_W(SEL_W)) u_irq (
        .pri_sel   (pri_sel_q),
        .aux_sel   (aux_sel_q),
        .pri_req   (pri_req),
        .aux_req   (aux_req),
        .irq_lines (irq_lines)
    );

    kbc_pulse_gen #(.LINES(PULSE_LINES), .LEN(PULSE_LEN)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (cmd_pulse),
        .sel_n     (bus_wdata[PULSE_LINES-1:0]),
        .pulse_out (pulse_out)
    );

    // Drive the remaining outputs from state.
    always_comb begin
        cp_valid  = ibf_q;
        cp_data   = ib_q;
        cp_is_cmd = ib_cmd_q;
        p2_out    = p2_q;
        kbd_en    = kbd_en_q;
    end

    p_cmd_sets_cd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_cmd) |=> cd_q);
    p_accept_drops_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_valid && cp_ready && !(bus_wr && (hit_data || hit_cmd))) |=> !cp_valid);
    p_a20_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        a20_fill |=> (p2_out[1] == $past(bus_wdata[1])));
    p_fast_no_ibf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_cmd && (bus_wdata == CMD_KBD_OFF || bus_wdata == CMD_KBD_ON)) |=> !cp_valid);
    p_read_clears_obf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_data && !ob_load) |=> !obf_q);
    p_unconnected_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_sel_q == IRQ_UNCONNECTED && aux_sel_q == IRQ_UNCONNECTED) |-> (irq_lines == '0));
endmodule

// File: tb/kbc_host_if_tb.sv
module kbc_host_if_tb;
    localparam int PULSE_LEN = 4;
    localparam int NVEC = 15;
    // {op[26:25], byte[24:17], status[16:9], p2[8:1], kbd_en[0]}
    // op: 0 data write, 1 command write, 3 command read
    localparam logic [26:0] VEC [NVEC] = '{
        {2'd1, 8'h20, 8'h0A, 8'hFF, 1'b1},
        {2'd0, 8'h55, 8'h02, 8'hFF, 1'b1},
        {2'd1, 8'hAD, 8'h08, 8'hFF, 1'b0},
        {2'd1, 8'hD1, 8'h08, 8'hFF, 1'b0},
        {2'd0, 8'h00, 8'h00, 8'hFD, 1'b0},
        {2'd1, 8'hAE, 8'h08, 8'hFD, 1'b1},
        {2'd1, 8'hD1, 8'h08, 8'hFD, 1'b1},
        {2'd0, 8'h02, 8'h00, 8'hFF, 1'b1},
        {2'd1, 8'hFF, 8'h08, 8'hFF, 1'b1},
        {2'd3, 8'h00, 8'h08, 8'hFF, 1'b1},
        {2'd1, 8'h20, 8'h0A, 8'hFF, 1'b1},
        {2'd1, 8'hD1, 8'h08, 8'hFF, 1'b1},
        {2'd0, 8'hFC, 8'h00, 8'hFD, 1'b1},
        {2'd1, 8'h20, 8'h0A, 8'hFD, 1'b1},
        {2'd0, 8'h02, 8'h02, 8'hFD, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'h0;
    logic [15:0] bus_addr = 16'h0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h0;
    logic [7:0]  bus_rdata;
    logic        cp_valid, cp_is_cmd;
    logic        cp_ready = 1'b0;
    logic [7:0]  cp_data;
    logic        ob_load = 1'b0, ob_aux = 1'b0;
    logic [7:0]  ob_byte = 8'h0;
    logic [1:0]  ccb_int_en = 2'b01;
    logic [15:0] irq_lines;
    logic [7:0]  p2_out;
    logic        kbd_en;
    logic [3:0]  pulse_out;

    int total = 0, bad = 0;
    logic [15:0] base = 16'h0060;
    logic [7:0]  rv;
    bit done = 0;

    always #5 clk = ~clk;

    kbc_host_if u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cp_valid(cp_valid), .cp_ready(cp_ready), .cp_data(cp_data),
        .cp_is_cmd(cp_is_cmd), .ob_load(ob_load), .ob_byte(ob_byte), .ob_aux(ob_aux),
        .ccb_int_en(ccb_int_en), .irq_lines(irq_lines), .p2_out(p2_out), .kbd_en(kbd_en),
        .pulse_out(pulse_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [15:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [15:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic cfg_wr(input logic [1:0] s, input logic [15:0] v);
        cfg_sel = s; cfg_wdata = v; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_ob(input logic [7:0] b, input logic x);
        ob_byte = b; ob_aux = x; ob_load = 1'b1;
        @(negedge clk);
        ob_load = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        base = 16'h0060;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R12 reset state
        host_rd(base + 4, rv);
        check("R12 status", rv, 8'h00);
        check("R12 p2", p2_out, 8'hFF);
        check("R12 kbd_en", kbd_en, 1'b1);
        check("R12 pulse", pulse_out, 4'h0);
        check("R12 cp_valid", cp_valid, 1'b0);

        // Vector walk: R2 R3 R4 R6 R7 R9
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op;
            op = VEC[i][26:25];
            if (op == 2'd0) host_wr(base, VEC[i][24:17]);
            else if (op == 2'd1) host_wr(base + 4, VEC[i][24:17]);
            else begin
                host_rd(base + 4, rv);
                check("R9 status read value", rv, VEC[i][16:9]);
            end
            host_rd(base + 4, rv);
            check("R2/R4/R7 status", rv, VEC[i][16:9]);
            check("R4 p2", p2_out, VEC[i][8:1]);
            check("R6 kbd_en", kbd_en, VEC[i][0]);
        end

        // R3 handoff of the pending data byte
        check("R3 valid", cp_valid, 1'b1);
        check("R3 data", cp_data, 8'h02);
        check("R3 is_cmd", cp_is_cmd, 1'b0);
        cp_ready = 1'b1; @(negedge clk); cp_ready = 1'b0;
        check("R3 accept clears", cp_valid, 1'b0);
        host_wr(base + 4, 8'h47);
        check("R3 cmd data", cp_data, 8'h47);
        check("R3 cmd flag", cp_is_cmd, 1'b1);
        cp_ready = 1'b1; @(negedge clk); cp_ready = 1'b0;
        host_rd(base + 4, rv);
        check("R3 ibf clear", rv[1], 1'b0);

        // R5 pulse: F6 selects lines 0 and 3
        host_wr(base + 4, 8'hF6);
        check("R5 mask", pulse_out, 4'b1001);
        check("R5 not forwarded", cp_valid, 1'b0);
        begin
            int n = 0;
            while (pulse_out != 4'h0 && n < 20) begin
                n++;
                @(negedge clk);
            end
            check("R5 length", n, PULSE_LEN);
        end

        // R8 R9 R10 output buffer and primary interrupt on line 1
        load_ob(8'h3C, 1'b0);
        check("R10 primary line 1", irq_lines, 16'h0002);
        host_rd(base + 4, rv);
        host_rd(base + 4, rv);
        check("R9 read keeps obf", rv[0], 1'b1);
        host_rd(base, rv);
        check("R8 read data", rv, 8'h3C);
        host_rd(base + 4, rv);
        check("R8 obf cleared", rv[0], 1'b0);
        check("R10 irq drops", irq_lines, 16'h0000);

        // R10 auxiliary gated by enable bit 1, on line 12
        load_ob(8'h5A, 1'b1);
        check("R10 aux disabled", irq_lines, 16'h0000);
        host_rd(base + 4, rv);
        check("R10 aux status bit5", rv[5], 1'b1);
        ccb_int_en = 2'b11; #1;
        check("R11 aux line 12", irq_lines, 16'h1000);
        host_rd(base, rv);
        ccb_int_en = 2'b00;
        load_ob(8'h44, 1'b0);
        check("R10 primary disabled", irq_lines, 16'h0000);
        host_rd(base, rv);
        ccb_int_en = 2'b01;

        // R11 relocation and disconnect
        cfg_wr(2'd1, 16'd5);
        load_ob(8'h11, 1'b0);
        check("R11 relocated line 5", irq_lines, 16'h0020);
        cfg_wr(2'd1, 16'hFFFF);
        check("R11 disconnected", irq_lines, 16'h0000);

        // R8 load and read in the same cycle: the load wins
        bus_addr = base; bus_rd = 1'b1; ob_byte = 8'h99; ob_aux = 1'b0; ob_load = 1'b1;
        #1 rv = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; ob_load = 1'b0;
        check("R8 old byte returned", rv, 8'h11);
        host_rd(base + 4, rv);
        check("R8 obf kept", rv[0], 1'b1);
        host_rd(base, rv);
        check("R8 new byte", rv, 8'h99);

        // R1 base relocation
        cfg_wr(2'd0, 16'h0200);
        host_wr(16'h0064, 8'h20);
        host_rd(16'h0204, rv);
        check("R1 old address ignored", rv[1], 1'b0);
        host_rd(16'h0064, rv);
        check("R1 old address reads FF", rv, 8'hFF);
        host_wr(16'h0204, 8'hAD);
        check("R1 new command port", kbd_en, 1'b0);
        cfg_wr(2'd0, 16'h0000);
        host_wr(16'h0004, 8'hAE);
        check("R1 base zero write ignored", kbd_en, 1'b0);
        host_rd(16'h0000, rv);
        check("R1 base zero reads FF", rv, 8'hFF);

        // R11 R12 selectors and base return on reset
        do_reset();
        load_ob(8'h01, 1'b0);
        check("R11 reset primary line 1", irq_lines, 16'h0002);
        host_rd(16'h0060, rv);
        check("R1 reset base", rv, 8'h01);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule